// File: doc/BRIEF.md
# PRBS-7 Line Self-Test Generator and Checker

This block provides an at-speed self-test for a serial link datapath. While the test enable input is low, it forwards the already encoded 20-bit line words to the serializer input register with one cycle of delay. While the enable is high, it ignores those words and sends raw 20-bit words cut from a period-127 pseudo-random bit stream. These words bypass the line encoder.

The receive side takes 20-bit words from the deserializer under the same enable. It locks onto the stream from the bits it receives, predicts every following bit, and drives one status bit. That bit is high while a clean pseudo-random stream is arriving and is pulled low by any bit error. An external or internal loopback path is needed to join the two halves into a built-in self-test.

Top module: `prbs7_bist`

## Requirements
- R1: While `test_en` is low, `line_word` equals the `norm_word` value that was present at the previous rising clock edge.
- R2: While `test_en` is high, `norm_word` has no effect. Each `line_word` holds the next 20 bits of the stream b[n] = b[n-6] XOR b[n-7], with the earliest bit in bit 0. The seven bits before b[0] are all ones, and this holds afresh each time the enable rises. The first word appears one cycle after `test_en` is first sampled high.
- R3: Under a steady enable, the generated word sequence repeats every 127 words.
- R4: The generator state is never all zeros.
- R5: `prbs_ok` is low during reset and in the cycle after any cycle in which `test_en` is sampled low.
- R6: The checker seeds itself from bits 0 to 6 of the first word it takes after enabling or after an error, and checks the remaining bits. `prbs_ok` goes high only after 20 consecutive error-free words, counting the seeding word.
- R7: A received word with any bit differing from the prediction drives `prbs_ok` low in the next cycle. `prbs_ok` then stays low for at least 19 further words while the checker reseeds and counts a new clean run.
- R8: A received stream that leaves the checker state all zeros counts as an error, so a constant-zero input never gives a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_en | input | 1 | Selects self-test mode for both generator and checker |
| norm_word | input | 20 | Encoded traffic word for the serializer |
| line_word | output | 20 | Word to the serializer input register |
| rx_word | input | 20 | Word from the deserializer, earliest bit in bit 0 |
| prbs_ok | output | 1 | High while a clean PRBS stream is being received |

## Verification
The generator is compared word by word against a bench model over more than one full period, while the normal-traffic input keeps changing. This separates a true substitution from a leak of traffic into the line. A clean loopback shows that lock takes the specified run length and no fewer words. Single-bit flips placed in the seeding bits and in the checked bits show that every mismatch is caught, and that recovery needs a full new clean run. A constant-zero receive stream tells a real lock apart from a checker that has seeded into the degenerate all-zero state.

// File: rtl/prbs7_bist.sv
module prbs7_bist #(
  parameter int W    = 20,
  parameter int LOCK = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         test_en,
  input  logic [W-1:0] norm_word,
  output logic [W-1:0] line_word,
  input  logic [W-1:0] rx_word,
  output logic         prbs_ok
);
  localparam int CW = $clog2(LOCK + 1);
  localparam logic [6:0] SEED = 7'h7F;

  function automatic logic [W+6:0] gen_step(input logic [6:0] s);
    logic [6:0] t;
    logic [W-1:0] w;
    t = s;
    for (int i = 0; i < W; i++) begin
      w[i] = t[6] ^ t[5];
      t = {t[5:0], w[i]};
    end
    return {t, w};
  endfunction

  function automatic logic [7:0] chk_step(input logic [6:0] s, input logic [W-1:0] rx,
                                          input logic first);
    logic [6:0] t;
    logic e, nb;
    t = s;
    e = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (first && i < 7) nb = rx[i];
      else begin
        nb = t[6] ^ t[5];
        if (nb != rx[i]) e = 1'b1;
      end
      t = {t[5:0], nb};
    end
    if (t == 7'd0) e = 1'b1;
    return {e, t};
  endfunction

  logic [6:0]    gst, cst;
  logic [W-1:0]  line_q;
  logic          seeded, ok_q;
  logic [CW-1:0] run;

  logic [W+6:0] g_nx;
  logic [7:0]   c_nx;
  logic         c_err;

  assign g_nx  = gen_step(gst);
  assign c_nx  = chk_step(cst, rx_word, !seeded);
  assign c_err = c_nx[7];

  assign line_word = line_q;
  assign prbs_ok   = ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gst    <= SEED;
      line_q <= '0;
      cst    <= SEED;
      seeded <= 1'b0;
      run    <= '0;
      ok_q   <= 1'b0;
    end else begin
      line_q <= test_en ? g_nx[W-1:0] : norm_word;
      gst    <= test_en ? g_nx[W+6:W] : SEED;
      if (!test_en || c_err) begin
        seeded <= 1'b0;
        run    <= '0;
        ok_q   <= 1'b0;
      end else begin
        seeded <= 1'b1;
        cst    <= c_nx[6:0];
        if (run != CW'(LOCK)) run <= run + 1'b1;
        ok_q   <= (run >= CW'(LOCK - 1));
      end
    end
  end

  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> line_word == $past(norm_word));
  a_r4_gen_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    gst != 7'd0);
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> !prbs_ok);
  a_r7_err_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && c_err) |=> !prbs_ok);
  a_r6_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prbs_ok) |-> $past(test_en));
endmodule

// File: tb/tb_prbs7_bist.sv
module tb_prbs7_bist;
  localparam int W = 20;
  logic clk = 1'b0, rst_n = 1'b0, test_en = 1'b0;
  logic [W-1:0] norm_word = '0, line_word, rx_word, flip = '0;
  logic zero_rx = 1'b0;
  logic prbs_ok;
  int errors = 0, checks = 0;
  bit refb [0:2700];

  always #2.5 clk = ~clk;

  assign rx_word = zero_rx ? '0 : (line_word ^ flip);

  prbs7_bist dut (.clk(clk), .rst_n(rst_n), .test_en(test_en), .norm_word(norm_word),
                  .line_word(line_word), .rx_word(rx_word), .prbs_ok(prbs_ok));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [W-1:0] ref_word(input int k);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = refb[7 + k*W + i];
    return w;
  endfunction

  task automatic t_reset();
    check("R5 reset ok", W'(prbs_ok), '0);
    check("R1 reset line", line_word, '0);
  endtask

  task automatic t_passthru();
    test_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      norm_word = W'(32'h3A5C1 * (k + 3));
      step(1);
      check("R1 passthru", line_word, W'(32'h3A5C1 * (k + 3)));
    end
  endtask

  task automatic t_gen();
    test_en = 1'b1;
    for (int k = 0; k < 130; k++) begin
      norm_word = W'(32'h9E37 * (k + 11));
      step(1);
      if (k < 6 || k == 127 || k == 128)
        check(k >= 127 ? "R3 period" : "R2 gen word", line_word, ref_word(k));
      else if (line_word !== ref_word(k)) check("R2 gen word", line_word, ref_word(k));
    end
    check("R3 repeat", line_word, ref_word(2));
    test_en = 1'b0;
    step(1);
    check("R5 drop on disable", W'(prbs_ok), '0);
    test_en = 1'b1;
    step(1);
    check("R2 reseed on enable", line_word, ref_word(0));
    test_en = 1'b0;
    step(2);
  endtask

  task automatic t_lock();
    test_en = 1'b1;
    step(19);
    check("R6 not before run", W'(prbs_ok), '0);
    step(11);
    check("R6 lock", W'(prbs_ok), 1);
  endtask

  task automatic t_flip(input logic [W-1:0] mask, input string tag);
    flip = mask;
    step(1);
    flip = '0;
    check({"R7 flip drop ", tag}, W'(prbs_ok), '0);
    step(18);
    check({"R7 held low ", tag}, W'(prbs_ok), '0);
    step(4);
    check({"R7 recover ", tag}, W'(prbs_ok), 1);
  endtask

  task automatic t_zero();
    test_en = 1'b0;
    step(2);
    zero_rx = 1'b1;
    test_en = 1'b1;
    step(40);
    check("R8 zero stream fails", W'(prbs_ok), '0);
    zero_rx = 1'b0;
    step(30);
    check("R8 recover after zeros", W'(prbs_ok), 1);
  endtask

  initial begin
    for (int n = 0; n < 7; n++) refb[n] = 1'b1;
    for (int n = 0; n < 2690; n++) refb[n+7] = refb[n+1] ^ refb[n];
    step(3);
    t_reset();
    rst_n = 1'b1;
    t_passthru();
    t_gen();
    t_lock();
    t_flip(20'h00001, "seed bit");
    t_flip(20'h80000, "top bit");
    t_flip(20'h00400, "mid bit");
    t_zero();
    test_en = 1'b0;
    step(1);
    check("R5 final disable", W'(prbs_ok), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule